// File: doc/BRIEF.md
# ADC Power Mode Controller

This block sequences the power state of an analog-to-digital converter from two control bits, an enable and a standby request. It drives the analog power-down and reduced-power controls and reports a two-bit mode status together with a ready flag. When the converter wakes, either from standby or from a full power-down, the block counts a fixed recovery interval in converter clock cycles and only then raises ready. Everything runs in the converter clock domain.

A small configuration word sits beside the sequencer. It may be written only while the enable bit is low. A write attempted while enabled is dropped and reported on a one-cycle error output, so that settings cannot change under a running converter. The conversion engine and the analog circuits themselves lie outside this block.

The mode status has three levels: 2'b00 powered down, 2'b01 standby, 2'b10 on. The on code covers both the recovery interval and normal operation; ready tells the two apart.

Top module: `adc_pwr_ctrl`

## Requirements
- R1: While `enable` is 0, `mode` reads 2'b00 and `ready` reads 0 in the same cycle, with no clock edge needed; any recovery count in progress is abandoned.
- R2: A clock edge that samples `enable`=1 and `standby`=1 moves the block to standby: after that edge `mode` is 2'b01, `stby_ctl` is 1 and `ready` is 0, including when it was on and ready before.
- R3: `mode` encodes 2'b00 for powered down, 2'b01 for standby and 2'b10 for on; `ready` is 1 only while `mode` is 2'b10.
- R4: A clock edge that samples `enable`=1 and `standby`=0 while in standby starts recovery: `mode` reads 2'b10 and `ready` stays 0 after that edge and the next WAKE_CYC-1 edges (WAKE_CYC=230), and `ready` is 1 after the edge WAKE_CYC+1 counted from the starting edge.
- R5: A standby request during recovery returns the block to standby at the next edge, and a later exit from standby counts the full WAKE_CYC interval again.
- R6: `pwr_dn` is 1 exactly when the block is powered down and `stby_ctl` exactly when it is in standby, both changing on a clock edge; after reset `pwr_dn`=1, `stby_ctl`=0, `mode`=2'b00, `ready`=0, `wr_err`=0 and `cfg_q`=0.
- R7: A clock edge with `cfg_wr`=1 and `enable`=0 loads `cfg_data` into `cfg_q`, and `wr_err` stays 0.
- R8: A clock edge with `cfg_wr`=1 and `enable`=1 leaves `cfg_q` unchanged and raises `wr_err` for exactly the one following cycle.
- R9: Setting `enable` with `standby`=0 from the powered-down state starts the same recovery as R4, with the same WAKE_CYC interval before `ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Module enable control bit |
| standby | input | 1 | Reduced-power request bit |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | CFG_W | Configuration write data |
| pwr_dn | output | 1 | Analog power-down control |
| stby_ctl | output | 1 | Analog reduced-power control |
| mode | output | 2 | Mode status: 00 down, 01 standby, 10 on |
| ready | output | 1 | Converter usable |
| cfg_q | output | CFG_W | Held configuration word |
| wr_err | output | 1 | One-cycle flag for a rejected configuration write |

## Verification
The properties take for granted that `enable`, `standby`, `cfg_wr` and `cfg_data` change only between clock edges and stay steady across each edge, so that an enable level seen combinationally on `mode` is the same level the next edge samples. The bench drives every input at the falling edge and samples outputs at the following falling edge, which keeps it inside that assumption. The recovery-length property relies on the on-but-not-ready status being unbroken from the start of recovery to the rise of ready; a dropped enable or a standby request always passes through another mode code, which restarts the count in the checker.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

    typedef enum logic [1:0] {
        PS_OFF  = 2'd0,
        PS_STBY = 2'd1,
        PS_WAKE = 2'd2,
        PS_ON   = 2'd3
    } pwr_state_e;

    localparam logic [1:0] MODE_OFF  = 2'b00;
    localparam logic [1:0] MODE_STBY = 2'b01;
    localparam logic [1:0] MODE_ON   = 2'b10;

    function automatic logic [1:0] mode_of(pwr_state_e s);
        logic [1:0] m;
        case (s)
            PS_OFF:  m = MODE_OFF;
            PS_STBY: m = MODE_STBY;
            default: m = MODE_ON;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/adc_pwr_timer.sv
module adc_pwr_timer #(
    parameter int unsigned WAKE_CYC = 230
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int unsigned CNT_W = (WAKE_CYC > 2) ? $clog2(WAKE_CYC) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(WAKE_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!run) begin
            t_d.cnt = LOAD;
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.cnt <= LOAD;
        end else begin
            t_q <= t_d;
        end
    end

    assign done = run && (t_q.cnt == '0);

endmodule

// File: rtl/adc_pwr_fsm.sv
module adc_pwr_fsm
    import adc_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       standby,
    input  logic       wake_done,
    output pwr_state_e state,
    output logic       wake_run,
    output logic       pwr_dn,
    output logic       stby_ctl,
    output logic       rdy
);
    typedef struct packed {
        pwr_state_e st;
        logic       pdn;
        logic       sby;
        logic       rdy;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        pwr_state_e nxt;
        nxt = f_q.st;
        if (!enable) begin
            nxt = PS_OFF;
        end else if (standby) begin
            nxt = PS_STBY;
        end else begin
            case (f_q.st)
                PS_OFF:  nxt = PS_WAKE;
                PS_STBY: nxt = PS_WAKE;
                PS_WAKE: nxt = wake_done ? PS_ON : PS_WAKE;
                default: nxt = PS_ON;
            endcase
        end
        f_d.st  = nxt;
        f_d.pdn = (nxt == PS_OFF);
        f_d.sby = (nxt == PS_STBY);
        f_d.rdy = (nxt == PS_ON);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.st  <= PS_OFF;
            f_q.pdn <= 1'b1;
            f_q.sby <= 1'b0;
            f_q.rdy <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign state    = f_q.st;
    assign wake_run = (f_q.st == PS_WAKE);
    assign pwr_dn   = f_q.pdn;
    assign stby_ctl = f_q.sby;
    assign rdy      = f_q.rdy;

endmodule

// File: rtl/adc_pwr_cfg.sv
module adc_pwr_cfg #(
    parameter int unsigned CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg,
    output logic             err
);
    typedef struct packed {
        logic [CFG_W-1:0] word;
        logic             err;
    } cfg_t;

    cfg_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.err = wr && lock;
        if (wr && !lock) begin
            c_d.word = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.word <= '0;
            c_q.err  <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cfg = c_q.word;
    assign err = c_q.err;

endmodule

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
    import adc_pwr_pkg::*;
#(
    parameter int unsigned WAKE_CYC = 230,
    parameter int unsigned CFG_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             standby,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_data,
    output logic             pwr_dn,
    output logic             stby_ctl,
    output logic [1:0]       mode,
    output logic             ready,
    output logic [CFG_W-1:0] cfg_q,
    output logic             wr_err
);
    pwr_state_e state;
    logic       wake_run;
    logic       wake_done;
    logic       rdy_q;

    adc_pwr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .standby   (standby),
        .wake_done (wake_done),
        .state     (state),
        .wake_run  (wake_run),
        .pwr_dn    (pwr_dn),
        .stby_ctl  (stby_ctl),
        .rdy       (rdy_q)
    );

    adc_pwr_timer #(.WAKE_CYC(WAKE_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (wake_run),
        .done  (wake_done)
    );

    adc_pwr_cfg #(.CFG_W(CFG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .lock  (enable),
        .wr    (cfg_wr),
        .wdata (cfg_data),
        .cfg   (cfg_q),
        .err   (wr_err)
    );

    // A cleared enable overrides the registered status at once.
    assign mode  = enable ? mode_of(state) : MODE_OFF;
    assign ready = enable && rdy_q;

endmodule

// File: rtl/adc_pwr_ctrl_chk.sv
module adc_pwr_ctrl_chk #(
    parameter int unsigned WAKE_CYC = 230,
    parameter int unsigned CFG_W    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             standby,
    input logic             cfg_wr,
    input logic [CFG_W-1:0] cfg_data,
    input logic             pwr_dn,
    input logic             stby_ctl,
    input logic [1:0]       mode,
    input logic             ready,
    input logic [CFG_W-1:0] cfg_q,
    input logic             wr_err
);
    localparam int unsigned RUN_W = $clog2(WAKE_CYC + 2);

    logic [RUN_W-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (mode == 2'b10 && !ready) begin
            if (run_cnt != '1) run_cnt <= run_cnt + 1'b1;
        end else begin
            run_cnt <= '0;
        end
    end

    a_r1_off_status: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (mode == 2'b00 && !ready));

    a_r1_off_power: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (pwr_dn && !stby_ctl));

    a_r2_standby_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && standby) |=> (stby_ctl && !ready && !pwr_dn));

    a_r3_ready_only_on: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mode == 2'b10));

    a_r4_recovery_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (run_cnt == RUN_W'(WAKE_CYC)));

    a_r6_controls_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_dn && stby_ctl));

    a_r7_write_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !enable) |=> (!wr_err && cfg_q == $past(cfg_data)));

    a_r8_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && enable) |=> (wr_err && $stable(cfg_q)));

    a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> !wr_err);

endmodule

bind adc_pwr_ctrl adc_pwr_ctrl_chk #(.WAKE_CYC(WAKE_CYC), .CFG_W(CFG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .standby  (standby),
    .cfg_wr   (cfg_wr),
    .cfg_data (cfg_data),
    .pwr_dn   (pwr_dn),
    .stby_ctl (stby_ctl),
    .mode     (mode),
    .ready    (ready),
    .cfg_q    (cfg_q),
    .wr_err   (wr_err)
);

// File: tb/adc_pwr_ctrl_bench.sv
module adc_pwr_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WAKE = 230;
    localparam int NV   = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       standby = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_data = 8'h00;
    logic       pwr_dn, stby_ctl, ready, wr_err;
    logic [1:0] mode;
    logic [7:0] cfg_q;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_pwr_ctrl u_adc_pwr_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .standby(standby),
        .cfg_wr(cfg_wr), .cfg_data(cfg_data), .pwr_dn(pwr_dn),
        .stby_ctl(stby_ctl), .mode(mode), .ready(ready),
        .cfg_q(cfg_q), .wr_err(wr_err)
    );

    // {en, sb, wr, data[7:0], mode[1:0], rdy, pdn, sby, err, cfg[7:0]}
    localparam logic [24:0] VEC [0:NV-1] = '{
        {1'b0,1'b0,1'b1,8'hA5, 2'b00,1'b0,1'b1,1'b0,1'b0,8'hA5},
        {1'b0,1'b1,1'b0,8'h00, 2'b00,1'b0,1'b1,1'b0,1'b0,8'hA5},
        {1'b1,1'b1,1'b0,8'h00, 2'b01,1'b0,1'b0,1'b1,1'b0,8'hA5},
        {1'b1,1'b1,1'b1,8'h3C, 2'b01,1'b0,1'b0,1'b1,1'b1,8'hA5},
        {1'b1,1'b1,1'b0,8'h00, 2'b01,1'b0,1'b0,1'b1,1'b0,8'hA5},
        {1'b1,1'b0,1'b0,8'h00, 2'b10,1'b0,1'b0,1'b0,1'b0,8'hA5},
        {1'b1,1'b1,1'b0,8'h00, 2'b01,1'b0,1'b0,1'b1,1'b0,8'hA5},
        {1'b0,1'b1,1'b0,8'h00, 2'b00,1'b0,1'b1,1'b0,1'b0,8'hA5},
        {1'b0,1'b0,1'b1,8'h5A, 2'b00,1'b0,1'b1,1'b0,1'b0,8'h5A}
    };
    string vtag [0:NV-1] = '{"R7", "R1", "R2", "R8", "R8", "R4", "R5", "R1", "R7"};

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R6 reset state
        chk("R6", "reset state", {pwr_dn, stby_ctl, mode, ready, wr_err, cfg_q},
            {1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 8'h00});

        for (int i = 0; i < NV; i++) begin
            enable   = VEC[i][24];
            standby  = VEC[i][23];
            cfg_wr   = VEC[i][22];
            cfg_data = VEC[i][21:14];
            step(1);
            chk(vtag[i], $sformatf("vector %0d", i),
                {mode, ready, pwr_dn, stby_ctl, wr_err, cfg_q}, VEC[i][13:0]);
        end
        cfg_wr = 1'b0;

        // R4 recovery from standby
        enable = 1'b1; standby = 1'b1;
        step(1);
        chk("R2", "standby from off", mode, 2'b01);
        standby = 1'b0;
        step(WAKE);
        chk("R4", "mode late in recovery", mode, 2'b10);
        chk("R4", "ready before interval ends", ready, 1'b0);
        step(1);
        chk("R4", "ready at interval end", ready, 1'b1);
        chk("R6", "controls when on", {pwr_dn, stby_ctl}, 2'b00);

        // R2 standby from on
        standby = 1'b1;
        step(1);
        chk("R2", "standby from on", {mode, ready, stby_ctl}, {2'b01, 1'b0, 1'b1});

        // R5 abort of recovery by standby
        standby = 1'b0;
        step(100);
        chk("R5", "mid recovery", {mode, ready}, {2'b10, 1'b0});
        standby = 1'b1;
        step(1);
        chk("R5", "abort to standby", mode, 2'b01);
        standby = 1'b0;
        step(WAKE);
        chk("R5", "restart not short", ready, 1'b0);
        step(1);
        chk("R5", "restart full length", ready, 1'b1);

        // R8 rejected write while on
        cfg_wr = 1'b1; cfg_data = 8'hFF;
        step(1);
        chk("R8", "err raised", wr_err, 1'b1);
        chk("R8", "cfg kept", cfg_q, 8'h5A);
        cfg_wr = 1'b0;
        step(1);
        chk("R8", "err one cycle", wr_err, 1'b0);

        // R1 immediate drop of status
        enable = 1'b0;
        #1;
        chk("R1", "immediate status", {mode, ready}, {2'b00, 1'b0});
        step(1);
        chk("R6", "power-down after edge", {pwr_dn, stby_ctl}, 2'b10);

        // R9 power-up straight into recovery, aborted by enable
        enable = 1'b1; standby = 1'b0;
        step(50);
        chk("R9", "recovery from off", {mode, ready, pwr_dn}, {2'b10, 1'b0, 1'b0});
        enable = 1'b0;
        #1;
        chk("R1", "abort by enable", {mode, ready}, {2'b00, 1'b0});
        step(1);
        enable = 1'b1;
        step(WAKE);
        chk("R9", "full count after abort", ready, 1'b0);
        step(1);
        chk("R9", "ready after power-up", {mode, ready}, {2'b10, 1'b1});
        chk("R3", "on code", mode, 2'b10);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule